// File: doc/BRIEF.md
# Chained Vectored Interrupt Responder

This block lets a peripheral on a multiplexed asynchronous bus raise one interrupt and answer the processor's acknowledge. The register block supplies three inputs: the interrupt enable, the READY flag, and an error condition. The block raises its request line when the enable is set and a condition is present. A condition is READY set by a finished transfer count or by peripheral attention, or an error such as a reference to missing memory.

The processor answers by asserting the data-in strobe without sync, and then the acknowledge grant on the chain input. If this device is requesting, it places its configured vector on the address/data lines, asserts reply and withdraws the request. When the processor has removed both data-in and the grant, the block drops reply and releases the lines together. If the device is not requesting, it passes the grant on to the next device down the chain. One interrupt is delivered per condition. A new one can occur only after the condition has gone away, which is when GO clears READY and any error has been removed.

Top module: `vint_responder`

## Requirements
- R1: `irq` rises one clock after an edge at which `irq_en` is 1, a condition is present and the block is armed. It falls one clock after an edge that sees `irq_en` at 0.
- R2: Either `ready` or `err` alone counts as a condition.
- R3: An acknowledge is recognised only when `iak_in` is 1 and `din` is 1 and `sync` is 0. With `sync` at 1, or with `din` at 0, a grant produces no `rply` and no `iak_out`, and any request stays pending.
- R4: An acknowledge recognised while `irq` is 1 sets `rply` and `vec_oe` one clock later. `irq` falls at that same clock.
- R5: `rply` and `vec_oe` stay at 1 while either `din` or `iak_in` is 1. Both fall one clock after an edge that sees `din` and `iak_in` both at 0.
- R6: An acknowledge recognised while `irq` is 0 sets `iak_out` one clock later, with `rply` kept at 0. `iak_out` falls one clock after `iak_in` falls.
- R7: While driven, `vec_bus[1:0]` reads 0 and `vec_bus[15:2]` reads `vec_cfg`. When not driven, `vec_bus` reads 0.
- R8: After an acknowledge, no new request arises while the condition persists. Once `ready` and `err` have both been 0 at one clock edge, the block re-arms and the next condition raises `irq` again.
- R9: While `rst_n` is 0 at a clock edge, `irq`, `rply`, `iak_out` and `vec_oe` are cleared, and the block is disarmed. A condition that is present from reset onward raises no request until it has first been removed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| irq_en | input | 1 | Interrupt enable from the register block |
| ready | input | 1 | READY flag (transfer count done or attention) |
| err | input | 1 | Error condition (missing memory or similar) |
| vec_cfg | input | 14 | Configured vector, bits 15..2 |
| din | input | 1 | Bus data-in strobe |
| sync | input | 1 | Bus sync |
| iak_in | input | 1 | Acknowledge grant from upstream |
| irq | output | 1 | Interrupt request |
| iak_out | output | 1 | Acknowledge grant to downstream |
| rply | output | 1 | Bus reply |
| vec_oe | output | 1 | Vector drive enable |
| vec_bus | output | 16 | Vector on address/data lines, zero when idle |

## Verification
The full request-acknowledge-release cycle is repeated across a sweep of vector values, including all zeros and all ones. This separates the bit placement and low-bit forcing on the lines from the handshake itself. Grants are also applied with sync present, with data-in absent, and with no request pending. These tell a genuine interrupt acknowledge apart from other bus traffic and from chain pass-through. Release is probed by dropping data-in and the grant in separate cycles. The arming is probed four ways: a persisting condition, a cleared-then-restored condition, an error-only condition, and a condition present from reset.

// File: rtl/vint_pkg.sv
package vint_pkg;
    // Handshake phases of the acknowledge sequencer
    typedef enum logic [1:0] {
        HS_IDLE  = 2'd0,
        HS_REPLY = 2'd1,
        HS_PASS  = 2'd2
    } hs_state_t;
endpackage

// File: rtl/vint_arm.sv
// Request generator: holds one armed flag per condition and drives the
// interrupt request. Assumes ready/err are synchronous to clk.
module vint_arm (
    input  logic clk,
    input  logic rst_n,
    input  logic irq_en,
    input  logic cond,
    input  logic take,
    output logic irq
);
    logic armed_q;
    logic irq_q;

    // Arm when the condition is absent, disarm when a vector is taken
    always_ff @(posedge clk) begin
        if (!rst_n)
            armed_q <= 1'b0;
        else if (!cond)
            armed_q <= 1'b1;
        else if (take)
            armed_q <= 1'b0;
    end

    // Register the request line
    always_ff @(posedge clk) begin
        if (!rst_n)
            irq_q <= 1'b0;
        else
            irq_q <= armed_q && cond && irq_en && !take;
    end

    assign irq = irq_q;

    p_irq_needs_en_r1: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> $past(irq_en));
    p_take_drops_r8: assert property (@(posedge clk) disable iff (!rst_n)
        take |=> !irq);
endmodule

// File: rtl/vint_ack.sv
// Acknowledge sequencer: answers an interrupt acknowledge (data-in without
// sync plus grant) with reply, or forwards the grant when not requesting.
// Assumes bus inputs are synchronised to clk.
module vint_ack
    import vint_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic iak_in,
    input  logic din,
    input  logic sync,
    input  logic req,
    output logic take,
    output logic rply,
    output logic iak_out,
    output logic drive
);
    hs_state_t st_q, st_d;
    logic      start;

    assign start = iak_in && din && !sync;
    assign take  = (st_q == HS_IDLE) && start && req;

    // Next-phase selection
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            HS_IDLE:  if (start) st_d = req ? HS_REPLY : HS_PASS;
            HS_REPLY: if (!din && !iak_in) st_d = HS_IDLE;
            HS_PASS:  if (!iak_in) st_d = HS_IDLE;
            default:  st_d = HS_IDLE;
        endcase
    end

    // Phase register
    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= HS_IDLE;
        else        st_q <= st_d;
    end

    assign rply    = (st_q == HS_REPLY);
    assign drive   = (st_q == HS_REPLY);
    assign iak_out = (st_q == HS_PASS);

    p_reply_cause_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rply) |-> $past(iak_in && din && !sync && req));
    p_release_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(rply) |-> $past(!din && !iak_in));
    p_pass_only_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(iak_out) |-> $past(!req && iak_in));
    p_exclusive_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !(rply && iak_out));
endmodule

// File: rtl/vint_vec.sv
// Vector driver: places the configured vector on the lines with the low
// LOW_ZERO bits forced to zero; lines read zero when not driving.
module vint_vec #(
    parameter int DATA_W   = 16,
    parameter int LOW_ZERO = 2,
    localparam int CFG_W   = DATA_W - LOW_ZERO
) (
    input  logic              drive,
    input  logic [CFG_W-1:0]  vec_cfg,
    output logic [DATA_W-1:0] bus,
    output logic              oe
);
    for (genvar i = 0; i < DATA_W; i++) begin : g_bit
        if (i < LOW_ZERO) begin : g_zero
            assign bus[i] = 1'b0;
        end else begin : g_cfg
            assign bus[i] = drive & vec_cfg[i-LOW_ZERO];
        end
    end
    assign oe = drive;
endmodule

// File: rtl/vint_responder.sv
// Top: chained vectored interrupt responder. Combines the request
// generator, the acknowledge sequencer and the vector driver.
module vint_responder #(
    parameter int DATA_W   = 16,
    parameter int LOW_ZERO = 2,
    localparam int CFG_W   = DATA_W - LOW_ZERO
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              irq_en,
    input  logic              ready,
    input  logic              err,
    input  logic [CFG_W-1:0]  vec_cfg,
    input  logic              din,
    input  logic              sync,
    input  logic              iak_in,
    output logic              irq,
    output logic              iak_out,
    output logic              rply,
    output logic              vec_oe,
    output logic [DATA_W-1:0] vec_bus
);
    logic take;
    logic drive;

    vint_arm u_arm (
        .clk(clk), .rst_n(rst_n), .irq_en(irq_en),
        .cond(ready | err), .take(take), .irq(irq)
    );

    vint_ack u_ack (
        .clk(clk), .rst_n(rst_n), .iak_in(iak_in), .din(din), .sync(sync),
        .req(irq), .take(take), .rply(rply), .iak_out(iak_out), .drive(drive)
    );

    vint_vec #(.DATA_W(DATA_W), .LOW_ZERO(LOW_ZERO)) u_vec (
        .drive(drive), .vec_cfg(vec_cfg), .bus(vec_bus), .oe(vec_oe)
    );

    p_reply_drops_irq_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rply) |-> !irq);
    p_vec_with_reply_r7: assert property (@(posedge clk) disable iff (!rst_n)
        rply |-> vec_oe);
endmodule

// File: tb/vint_responder_test.sv
module vint_responder_test;
    localparam int CLK_PERIOD = 10;
    localparam int DW = 16;
    localparam int LZ = 2;

    logic clk = 1'b0;
    logic rst_n, irq_en, ready, err, din, sync, iak_in;
    logic [DW-LZ-1:0] vec_cfg;
    logic irq, iak_out, rply, vec_oe;
    logic [DW-1:0] vec_bus;
    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    vint_responder #(.DATA_W(DW), .LOW_ZERO(LZ)) uut (
        .clk(clk), .rst_n(rst_n), .irq_en(irq_en), .ready(ready), .err(err),
        .vec_cfg(vec_cfg), .din(din), .sync(sync), .iak_in(iak_in),
        .irq(irq), .iak_out(iak_out), .rply(rply), .vec_oe(vec_oe),
        .vec_bus(vec_bus)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic bus_idle();
        din = 0; sync = 0; iak_in = 0;
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog expired");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        rst_n = 0; irq_en = 1; ready = 1; err = 0; vec_cfg = '0; bus_idle();
        @(negedge clk); tick(); tick();
        // R9: reset state
        chk("R9 irq in reset", irq, 0);
        chk("R9 rply in reset", rply, 0);
        chk("R9 iak_out in reset", iak_out, 0);
        chk("R9 vec_oe in reset", vec_oe, 0);
        rst_n = 1;
        tick(); tick(); tick();
        // R9: condition present since reset raises nothing
        chk("R9 no irq from held condition", irq, 0);
        ready = 0; tick();
        ready = 1; tick();
        chk("R9 irq after first removal", irq, 1);

        // R3: sync high blocks acknowledge
        iak_in = 1; din = 1; sync = 1; tick(); tick();
        chk("R3 sync blocks rply", rply, 0);
        chk("R3 sync blocks iak_out", iak_out, 0);
        chk("R3 request kept", irq, 1);
        // R3: grant without din
        sync = 0; din = 0; tick(); tick();
        chk("R3 no din no rply", rply, 0);
        chk("R3 no din no iak_out", iak_out, 0);
        chk("R3 request still kept", irq, 1);
        iak_in = 0; tick();

        // R4/R5/R7/R8 sweep over vectors
        for (int i = 0; i < 48; i++) begin
            logic [DW-LZ-1:0] v;
            if (i == 0) v = '0;
            else if (i == 1) v = '1;
            else v = DW'(i * 1237 + 5) ;
            vec_cfg = v;
            if (i > 0) begin
                ready = 0; tick(); // R8 re-arm
                ready = 1; tick();
                chk("R8 rearmed irq", irq, 1);
            end
            chk("R7 idle bus zero", vec_bus, 0);
            iak_in = 1; din = 1; sync = 0; tick();
            chk("R4 rply set", rply, 1);
            chk("R4 irq dropped", irq, 0);
            chk("R4 vec_oe set", vec_oe, 1);
            chk("R7 vector on bus", vec_bus, {16'(v), 2'b00} >> 0 & 32'hFFFF);
            din = 0; tick();
            chk("R5 rply held with iak_in", rply, 1);
            chk("R5 vec held with iak_in", vec_oe, 1);
            iak_in = 0; tick();
            chk("R5 rply released", rply, 0);
            chk("R5 vec released", vec_bus, 0);
            tick(); tick();
            chk("R8 no repeat while condition held", irq, 0);
        end

        // R6: pass-through when not requesting
        iak_in = 1; din = 1; tick();
        chk("R6 iak_out forwarded", iak_out, 1);
        chk("R6 no rply when forwarding", rply, 0);
        din = 0; tick();
        chk("R6 forward held while iak_in", iak_out, 1);
        iak_in = 0; tick();
        chk("R6 iak_out falls", iak_out, 0);

        // R2: error alone
        ready = 0; tick();
        err = 1; tick();
        chk("R2 err raises irq", irq, 1);
        iak_in = 1; din = 1; tick();
        chk("R2 err vector reply", rply, 1);
        bus_idle(); tick();

        // R1: enable gating
        err = 0; irq_en = 0; tick();
        ready = 1; tick(); tick();
        chk("R1 no irq when disabled", irq, 0);
        irq_en = 1; tick();
        chk("R1 irq once enabled", irq, 1);
        irq_en = 0; tick();
        chk("R1 irq falls when disabled", irq, 0);
        irq_en = 1; tick();
        chk("R1 irq returns", irq, 1);

        // R9: reset clears a pending request
        rst_n = 0; tick();
        chk("R9 reset clears irq", irq, 0);
        rst_n = 1; tick(); tick();
        chk("R9 disarmed after reset", irq, 0);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule